// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-programmed SPI master for talking to a serial flash. Eight byte-wide registers sit behind a simple write-strobe host port. The host loads an opcode, up to three address bytes and one trailing data byte. It then writes a control word, and that write launches exactly one SPI transaction. The control word packs three things: a length code for the bytes sent, a count of bytes to read back, and a launch nibble that also picks the SCK rate.

During the transaction chip select stays low the whole time. First 1, 2, 4 or 5 bytes go out on MOSI. Then 0 to 3 bytes are clocked in from MISO while zeros are driven out, and the received bytes land in the read-data registers. The busy bit lets the host poll for completion before it reads results or launches the next command.

The controller is a four-state machine:
- IDLE waits for a valid launch. On a launch, IDLE goes to LOAD.
- LOAD lowers chip select and hands one byte to the shifter, then goes to SHIFT.
- SHIFT waits for the shifter's byte-complete pulse. It goes back to LOAD when more bytes remain and on to CLOSE after the last byte.
- CLOSE raises chip select for one cycle while still reporting busy, then returns to IDLE.

Top module: `sfc_cmd_engine`

## Requirements
- R1: Bit 7 of a read at offset 0 is busy. It reads 1 from the cycle after an accepted launch write. It reads 0 only in the cycle after the first cycle in which spi_cs_n is back high, so busy and the high chip select overlap by one cycle.
- R2: The byte written at offset 1 is always the first byte on the wire.
- R3: For length codes 2 and 3, the address follows the opcode: first the byte at offset 4, then offset 3, then offset 2.
- R4: For length codes 1 and 3, the last byte sent comes from offset 7.
- R5: Control bits [1:0] set the bytes sent: code 0 sends 1 byte, 1 sends 2, 2 sends 4 and 3 sends 5. Each launch gives exactly one chip-select pulse, and that pulse carries exactly the bytes sent plus the bytes read.
- R6: Control bits [3:2] give the read count N, from 0 to 3. While reading, MOSI carries 0x00. The received bytes go to offsets 5, 6 and 7 in arrival order. Read-data offsets at or beyond N keep their earlier contents.
- R7: A control upper nibble of 4 launches with SCK half-period SLOW_HALF clocks. An upper nibble of 5 launches with half-period FAST_HALF clocks.
- R8: A control write whose upper nibble is neither 4 nor 5 launches nothing: spi_cs_n stays high and busy stays 0.
- R9: SPI mode 0 is used. SCK idles low and is low whenever chip select is high. MOSI changes only while SCK is low, MSB first, and MISO is sampled on SCK rising.
- R10: Host writes to any offset while busy are ignored, including a second launch.
- R11: After reset, every register reads 0, spi_cs_n is 1 and spi_sck is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data at reg_addr. Offset 0 returns busy in bit 7 and the last launch's low control bits below it |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A scoreboard predicts every byte that should appear on the wire, so a design that fetched the address from offsets 2,3,4 in ascending order, or dropped the offset-7 trailer, would show a mismatched or missing byte. Each launch is also checked for one chip-select pulse and the right byte total, so a wrong length decode gives a short or long frame. Busy is sampled around the rise of chip select: a design that dropped busy together with chip select would be caught in that single overlap cycle. Launches with bad nibbles, and writes and relaunches issued mid-transaction, must leave the wire silent and the opcode intact. Partial reads must leave the untouched read-data offsets as they were.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_CLOSE
    } sfc_state_e;

    localparam logic [3:0] LAUNCH_SLOW = 4'h4;
    localparam logic [3:0] LAUNCH_FAST = 4'h5;
    localparam logic [2:0] CTRL_SLOT   = 3'd0;
    localparam logic [2:0] OPCODE_SLOT = 3'd1;
    localparam logic [2:0] RX_BASE     = 3'd5;

    // bytes sent for each 2-bit length code
    function automatic logic [3:0] wr_count(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            2'd2:    return 4'd4;
            default: return 4'd5;
        endcase
    endfunction

    // register slot feeding wire byte idx; address slots run downward
    function automatic logic [2:0] tx_slot(input logic [1:0] code, input logic [3:0] idx);
        case (idx)
            4'd0:    return OPCODE_SLOT;
            4'd1:    return (code == 2'd1) ? 3'd7 : 3'd4;
            4'd2:    return 3'd3;
            4'd3:    return 3'd2;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/sfc_rate_tick.sv
module sfc_rate_tick #(
    parameter int SLOW_HALF = 3,
    parameter int FAST_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast,
    output logic tick
);
    localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CW       = $clog2(MAX_HALF + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        limit = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
        tick  = en && (cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!en)    cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sfc_byte_shift.sv
module sfc_byte_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              active,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh;
    logic [BW-1:0]     bit_cnt;

    assign mosi = sh[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            rx_byte <= '0;
            bit_cnt <= '0;
            active  <= 1'b0;
            sck     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                sh      <= tx_byte;
                bit_cnt <= '0;
                active  <= 1'b1;
                sck     <= 1'b0;
            end else if (active && tick) begin
                if (!sck) begin
                    sck     <= 1'b1;                        // rising: sample
                    rx_byte <= {rx_byte[BYTE_W-2:0], miso};
                end else begin
                    sck <= 1'b0;                            // falling: advance
                    if (bit_cnt == LAST_BIT) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        sh      <= {sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // mode 0: data only moves while SCK is low
    assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> !sck);

endmodule

// File: rtl/sfc_cmd_engine.sv
module sfc_cmd_engine
    import sfc_pkg::*;
#(
    parameter int SLOW_HALF = 3,
    parameter int FAST_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int BYTE_W = 8;
    localparam int NREG   = 8;

    sfc_state_e  state_q, state_d;
    logic [BYTE_W-1:0] regs [NREG];
    logic [1:0]  wcode_q;
    logic [1:0]  rcnt_q;
    logic        fast_q;
    logic [3:0]  idx_q;

    logic        busy;
    logic        launch_ok;
    logic        go;
    logic        sh_start, sh_done, sh_active, tick;
    logic [BYTE_W-1:0] tx_byte, rx_byte;
    logic [3:0]  wr_n, total, rx_rel;
    logic        in_rx, last_byte;
    logic [2:0]  rx_slot;

    always_comb begin
        launch_ok = (reg_wdata[7:4] == LAUNCH_SLOW) || (reg_wdata[7:4] == LAUNCH_FAST);
        go        = reg_we && (reg_addr == CTRL_SLOT) && (state_q == ST_IDLE) && launch_ok;
        wr_n      = wr_count(wcode_q);
        total     = wr_n + {2'b00, rcnt_q};
        in_rx     = (idx_q >= wr_n);
        last_byte = ((idx_q + 4'd1) == total);
        rx_rel    = idx_q - wr_n;
        rx_slot   = RX_BASE + rx_rel[2:0];
        tx_byte   = in_rx ? '0 : regs[tx_slot(wcode_q, idx_q)];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (sh_done) state_d = last_byte ? ST_CLOSE : ST_LOAD;
            ST_CLOSE: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        busy     = 1'b1;
        spi_cs_n = 1'b1;
        sh_start = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_LOAD:  begin spi_cs_n = 1'b0; sh_start = 1'b1; end
            ST_SHIFT: spi_cs_n = 1'b0;
            ST_CLOSE: spi_cs_n = 1'b1;
        endcase
    end

    // register file and transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
            wcode_q <= '0;
            rcnt_q  <= '0;
            fast_q  <= 1'b0;
            idx_q   <= '0;
        end else begin
            if (go) begin
                wcode_q         <= reg_wdata[1:0];
                rcnt_q          <= reg_wdata[3:2];
                fast_q          <= reg_wdata[4];
                idx_q           <= '0;
                regs[CTRL_SLOT] <= {1'b0, reg_wdata[6:0]};
            end else if (state_q == ST_IDLE && reg_we && reg_addr != CTRL_SLOT) begin
                regs[reg_addr] <= reg_wdata;
            end
            if (state_q == ST_SHIFT && sh_done) begin
                idx_q <= idx_q + 4'd1;
                if (in_rx) regs[rx_slot] <= rx_byte;
            end
        end
    end

    always_comb begin
        reg_rdata = regs[reg_addr];
        if (reg_addr == CTRL_SLOT) reg_rdata[7] = busy;
    end

    sfc_rate_tick #(
        .SLOW_HALF (SLOW_HALF),
        .FAST_HALF (FAST_HALF)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sh_active),
        .fast  (fast_q),
        .tick  (tick)
    );

    sfc_byte_shift #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .tick    (tick),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .active  (sh_active),
        .done    (sh_done),
        .rx_byte (rx_byte)
    );

    assert_busy_after_go_R1: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    assert_sck_low_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    assert_bad_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == CTRL_SLOT && !busy && !launch_ok) |=> (spi_cs_n && !busy));

    assert_opcode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == OPCODE_SLOT) |=> $stable(regs[OPCODE_SLOT]));

endmodule

// File: tb/sfc_cmd_engine_bench.sv
module sfc_cmd_engine_bench;
    localparam int SLOW_HALF = 3;
    localparam int FAST_HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

    always #5 clk = ~clk;

    sfc_cmd_engine #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_sfc_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model: streams resp[] on MISO, changing on SCK falling edges
    logic [7:0] resp [8];
    logic [5:0] slv_bit = '0;
    always @(negedge spi_sck) if (!spi_cs_n) slv_bit = slv_bit + 6'd1;
    always @(posedge spi_cs_n) slv_bit = '0;
    assign spi_miso = resp[slv_bit[5:3]][3'd7 - slv_bit[2:0]];

    // scoreboard
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] mon_sh = '0;
    int mon_bits = 0, frame_bytes = 0, cs_falls = 0;
    realtime t_rise = 0, hi_ns = 0;

    always @(negedge spi_cs_n) begin
        frame_bytes = 0;
        mon_bits = 0;
        cs_falls++;
    end

    always @(posedge spi_sck) begin
        t_rise = $realtime;
        mon_sh = {mon_sh[6:0], spi_mosi};
        mon_bits++;
        if (mon_bits == 8) begin
            mon_bits = 0;
            frame_bytes++;
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected wire byte", mon_sh, 0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(mon_sh == e, t, mon_sh, e);
            end
        end
    end

    always @(negedge spi_sck) hi_ns = $realtime - t_rise;

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic run_cmd(input logic [3:0] nib, input logic [1:0] wcode, input logic [1:0] rcnt,
                           input logic [7:0] op, input logic [7:0] a4, input logic [7:0] a3,
                           input logic [7:0] a2, input logic [7:0] d7, input bit poke_busy);
        logic [7:0] v, snap [3];
        int nwr, falls0;
        bit prev_cs;
        wr(3'd1, op); wr(3'd4, a4); wr(3'd3, a3); wr(3'd2, a2); wr(3'd7, d7);
        nwr = (wcode == 0) ? 1 : (wcode == 1) ? 2 : (wcode == 2) ? 4 : 5;
        push(op, "R2 opcode first");
        if (wcode >= 2) begin
            push(a4, "R3 address byte from offset 4");
            push(a3, "R3 address byte from offset 3");
            push(a2, "R3 address byte from offset 2");
        end
        if (wcode == 1 || wcode == 3) push(d7, "R4 trailer from offset 7");
        for (int i = 0; i < rcnt; i++) push(8'h00, "R6 zero fill while reading");
        for (int i = 0; i < 3; i++) rd(3'(5 + i), snap[i]);
        falls0 = cs_falls;
        wr(3'd0, {nib, rcnt, wcode});
        rd(3'd0, v);
        chk(v[7] == 1'b1, "R1 busy after launch", v[7], 1);
        if (poke_busy) begin
            wr(3'd1, 8'hEE);
            wr(3'd0, 8'h5F);
        end
        prev_cs = spi_cs_n;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            rd(3'd0, v);
            if (!v[7]) break;
            prev_cs = spi_cs_n;
        end
        chk(prev_cs && spi_cs_n, "R1 busy outlasts chip select", {prev_cs, spi_cs_n}, 3);
        chk(frame_bytes == nwr + rcnt, "R5 frame byte total", frame_bytes, nwr + rcnt);
        chk(exp_q.size() == 0, "R5 all predicted bytes seen", exp_q.size(), 0);
        chk(cs_falls == falls0 + 1, "R5 one chip-select pulse", cs_falls - falls0, 1);
        chk(hi_ns == ((nib == 4'h5) ? FAST_HALF : SLOW_HALF) * 10.0, "R7 SCK half period",
            int'(hi_ns), ((nib == 4'h5) ? FAST_HALF : SLOW_HALF) * 10);
        chk(spi_sck == 1'b0, "R9 SCK idles low", spi_sck, 0);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] e;
            e = (i < rcnt) ? resp[nwr + i] : snap[i];
            rd(3'(5 + i), v);
            chk(v == e, "R6 R9 read-data offset", v, e);
        end
        if (poke_busy) begin
            rd(3'd1, v);
            chk(v == op, "R10 opcode kept during busy write", v, op);
            repeat (40) @(negedge clk);
            chk(cs_falls == falls0 + 1, "R10 relaunch while busy ignored", cs_falls - falls0, 1);
        end
    endtask

    task automatic bad_launch(input logic [7:0] ctrl);
        logic [7:0] v;
        int falls0;
        falls0 = cs_falls;
        wr(3'd0, ctrl);
        rd(3'd0, v);
        chk(v[7] == 1'b0, "R8 no busy on bad launch", v[7], 0);
        repeat (30) @(negedge clk);
        chk(cs_falls == falls0 && spi_cs_n, "R8 no frame on bad launch", cs_falls - falls0, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) resp[i] = 8'(8'h3A + i * 8'h29);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v;
            rd(3'(i), v);
            chk(v == 8'h00, "R11 register reset value", v, 0);
        end
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R11 pins after reset", {spi_cs_n, spi_sck}, 2);

        run_cmd(4'h5, 2'd0, 2'd0, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        run_cmd(4'h4, 2'd2, 2'd3, 8'h03, 8'h12, 8'h34, 8'h56, 8'h77, 0);
        run_cmd(4'h5, 2'd3, 2'd1, 8'h0B, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 0);
        run_cmd(4'h5, 2'd1, 2'd2, 8'h01, 8'h00, 8'h00, 8'h00, 8'h9C, 0);
        run_cmd(4'h4, 2'd0, 2'd3, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        run_cmd(4'h4, 2'd3, 2'd0, 8'h02, 8'h80, 8'h01, 8'hFE, 8'h5A, 0);
        bad_launch(8'h63);
        bad_launch(8'h05);
        bad_launch(8'hF7);
        run_cmd(4'h5, 2'd2, 2'd0, 8'hD8, 8'h44, 8'h55, 8'h66, 8'h00, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule